// File: doc/BRIEF.md
# Single-Bus Microcoded-Style Processor Core

This block is a small 16-bit processor core in which every internal transfer travels over one shared bus. It holds sixteen general registers, a program counter, an instruction register, a memory address latch, a memory data latch, an operand latch in front of the ALU and a result latch behind it. A hardwired step sequencer raises, in each clock cycle, the strobes that choose which single source drives the bus and which destinations capture it.

The core repeats a fetch sequence and an execute sequence. It runs until it decodes an opcode it does not define, then halts. Memory is reached only through the address and data latches. A request is held until the memory raises a completion pulse, so memories of any latency can be attached.

Instruction word layout (bit positions are behaviour): opcode in [15:12], destination register in [11:8], source register in [7:4], and [3:0] ignored.

Top module: `sbus_core`

## Requirements
- R1: A synchronous active-high `rst` clears the PC, all registers, the step counter and `halted`. While reset is high, `memRead` and `memWrite` are low. The first fetch after reset reads address 0.
- R2: A fetch copies the PC to `memAddr` and reads that word into the instruction register. The PC then advances by one, so successive instructions are read from successive addresses. A fetch takes L+2 cycles, where L is the number of cycles the memory takes to raise `memDone`.
- R3: In every step at most one source (PC, data latch, result latch or one register) drives the internal bus.
- R4: A step that waits on memory holds `memRead` or `memWrite` and does not advance until `memDone` is high. The two requests are never raised together.
- R5: Bits [3:0] of the instruction word have no effect on execution.
- R6: Opcode 1 (load) sets R[dst] = M[R[src]] and uses L+2 cycles after the fetch. `memAddr` carries the full 16-bit value of R[src].
- R7: Opcode 2 (store) writes R[src] to address R[dst] through `memAddr`/`memWdata` with `memWrite`, and uses L+2 cycles after the fetch.
- R8: Opcode 3 (move) sets R[dst] = R[src] in one cycle after the fetch.
- R9: Opcode 4 (add) sets R[dst] = R[dst] + R[src] modulo 2^16 in three cycles after the fetch.
- R10: Any other opcode (0 and 5 to 15) raises `halted` one cycle after its fetch completes. After that, `halted` stays high and no further memory request is made until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| memRdata | input | 16 | Read data, sampled when `memDone` is high during a read |
| memDone | input | 1 | Memory completion pulse for the pending request |
| memAddr | output | 16 | Address from the memory address latch |
| memWdata | output | 16 | Write data from the memory data latch |
| memRead | output | 1 | Read request, held until `memDone` |
| memWrite | output | 1 | Write request, held until `memDone` |
| halted | output | 1 | High once an undefined opcode has been decoded |

## Verification
With memory latency L, every fetch is due L+2 cycles after it starts. After the fetch, a load or store is due L+2 cycles later, a move 1 cycle later, an add 3 cycles later and a halt 1 cycle later. The bench models memory with a programmable L and counts cycles from reset release to the first falling edge where `halted` is high. It compares that count with the sum of the per-instruction figures, so any extra or missing step in a sequence shows up as a count mismatch. Register results leave the core only through stores, and the bench checks them in the logged write addresses and data. The same program is run at two latencies to show that the wait steps stretch with L and nothing else does.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int DATA_W    = 16;
  localparam int SEL_W     = 4;
  localparam int NREG      = 1 << SEL_W;
  localparam int OP_W      = 4;
  localparam int STEP_W    = 3;

  typedef enum logic [1:0] { ALU_ADD, ALU_SUB, ALU_XOR } aluOp_t;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_MOVE  = 4'd3,
    OP_ADD   = 4'd4
  } opcode_t;

  typedef struct packed {
    logic             pcOut;
    logic             pcIn;
    logic             marIn;
    logic             mdrOut;
    logic             mdrIn;
    logic             irIn;
    logic             yIn;
    logic             zOut;
    logic             zIn;
    logic             regOut;
    logic             regIn;
    logic [SEL_W-1:0] regOutSel;
    logic [SEL_W-1:0] regInSel;
    aluOp_t           aluOp;
    logic             zeroA;
    logic             carryIn;
    logic             memRead;
    logic             memWrite;
  } strobes_t;
endpackage

// File: rtl/sbus_dpath.sv
module sbus_dpath
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          ctl,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memDone,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] irWord
);
  logic [DATA_W-1:0] pc, mar, mdr, ir, yLat, zLat, bus, aluA, aluRes;
  logic [DATA_W-1:0] regs [NREG];

  // shared bus: OR of gated sources, one-hot by construction of the sequencer
  always_comb begin
    bus = '0;
    if (ctl.pcOut)  bus = bus | pc;
    if (ctl.mdrOut) bus = bus | mdr;
    if (ctl.zOut)   bus = bus | zLat;
    if (ctl.regOut) bus = bus | regs[ctl.regOutSel];
  end

  always_comb begin
    aluA = ctl.zeroA ? '0 : yLat;
    case (ctl.aluOp)
      ALU_SUB: aluRes = aluA - bus;
      ALU_XOR: aluRes = aluA ^ bus;
      default: aluRes = aluA + bus + {{(DATA_W-1){1'b0}}, ctl.carryIn};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      mar  <= '0;
      mdr  <= '0;
      ir   <= '0;
      yLat <= '0;
      zLat <= '0;
    end else begin
      if (ctl.pcIn)  pc   <= bus;
      if (ctl.marIn) mar  <= bus;
      if (ctl.irIn)  ir   <= bus;
      if (ctl.yIn)   yLat <= bus;
      if (ctl.zIn)   zLat <= aluRes;
      if (ctl.mdrIn)                      mdr <= bus;
      else if (ctl.memRead && memDone)    mdr <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst) regs[i] <= '0;
      else if (ctl.regIn && ctl.regInSel == SEL_W'(i)) regs[i] <= bus;
    end
  end

  assign memAddr  = mar;
  assign memWdata = mdr;
  assign irWord   = ir;

  assert_one_source_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.pcOut, ctl.mdrOut, ctl.zOut, ctl.regOut}));

  assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ctl.irIn |=> $stable(ir));

  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ctl.pcIn |=> $stable(pc));
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] irWord,
  input  logic              memDone,
  output strobes_t          ctl,
  output logic              halted
);
  localparam logic [STEP_W-1:0] ST_F0 = 3'd0, ST_F1 = 3'd1, ST_F2 = 3'd2,
                                ST_E0 = 3'd3, ST_E1 = 3'd4, ST_E2 = 3'd5;

  logic [STEP_W-1:0] step;
  logic [OP_W-1:0]   opc;
  logic [SEL_W-1:0]  dstSel, srcSel;
  logic              hold, done, stopNow;

  assign opc    = irWord[15:12];
  assign dstSel = irWord[11:8];
  assign srcSel = irWord[7:4];

  always_comb begin
    ctl     = '0;
    hold    = 1'b0;
    done    = 1'b0;
    stopNow = 1'b0;
    if (!halted) begin
      case (step)
        ST_F0: begin
          ctl.pcOut = 1'b1; ctl.marIn = 1'b1;
          ctl.zeroA = 1'b1; ctl.carryIn = 1'b1; ctl.aluOp = ALU_ADD; ctl.zIn = 1'b1;
        end
        ST_F1: begin
          ctl.zOut = 1'b1; ctl.pcIn = 1'b1; ctl.memRead = 1'b1;
          hold = !memDone;
        end
        ST_F2: begin
          ctl.mdrOut = 1'b1; ctl.irIn = 1'b1;
        end
        ST_E0: begin
          case (opc)
            OP_LOAD:  begin ctl.regOut = 1'b1; ctl.regOutSel = srcSel; ctl.marIn = 1'b1; end
            OP_STORE: begin ctl.regOut = 1'b1; ctl.regOutSel = dstSel; ctl.marIn = 1'b1; end
            OP_MOVE:  begin
              ctl.regOut = 1'b1; ctl.regOutSel = srcSel;
              ctl.regIn  = 1'b1; ctl.regInSel  = dstSel; done = 1'b1;
            end
            OP_ADD:   begin ctl.regOut = 1'b1; ctl.regOutSel = dstSel; ctl.yIn = 1'b1; end
            default:  stopNow = 1'b1;
          endcase
        end
        ST_E1: begin
          case (opc)
            OP_LOAD:  begin ctl.memRead = 1'b1; hold = !memDone; end
            OP_STORE: begin ctl.regOut = 1'b1; ctl.regOutSel = srcSel; ctl.mdrIn = 1'b1; end
            default:  begin
              ctl.regOut = 1'b1; ctl.regOutSel = srcSel;
              ctl.aluOp = ALU_ADD; ctl.zIn = 1'b1;
            end
          endcase
        end
        default: begin
          done = 1'b1;
          case (opc)
            OP_LOAD:  begin ctl.mdrOut = 1'b1; ctl.regIn = 1'b1; ctl.regInSel = dstSel; end
            OP_STORE: begin ctl.memWrite = 1'b1; hold = !memDone; done = memDone; end
            default:  begin ctl.zOut = 1'b1; ctl.regIn = 1'b1; ctl.regInSel = dstSel; end
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= ST_F0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (stopNow)   halted <= 1'b1;
      else if (done) step   <= ST_F0;
      else if (!hold) step  <= step + 1'b1;
    end
  end

  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ((ctl.memRead || ctl.memWrite) && !memDone) |=> $stable(step));

  assert_rw_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(ctl.memRead && ctl.memWrite));

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !ctl.memRead && !ctl.memWrite));
endmodule

// File: rtl/sbus_core.sv
module sbus_core
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memDone,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memRead,
  output logic              memWrite,
  output logic              halted
);
  strobes_t          ctl;
  logic [DATA_W-1:0] irWord;

  sbus_ctrl u_ctrl (
    .clk(clk), .rst(rst), .irWord(irWord), .memDone(memDone),
    .ctl(ctl), .halted(halted)
  );

  sbus_dpath u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .memRdata(memRdata), .memDone(memDone),
    .memAddr(memAddr), .memWdata(memWdata), .irWord(irWord)
  );

  assign memRead  = ctl.memRead;
  assign memWrite = ctl.memWrite;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!halted));
endmodule

// File: tb/tb_sbus_core.sv
module tb_sbus_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] memRdata = '0;
  logic        memDone = 1'b0;
  logic [15:0] memAddr, memWdata;
  logic        memRead, memWrite, halted;

  int total = 0;
  int bad = 0;
  int lat = 2;
  int waitCnt = 0;
  logic [15:0] mem [256];
  logic [15:0] rdLog [64];
  logic [15:0] wrAddr [64];
  logic [15:0] wrData [64];
  int rdCount = 0;
  int wrCount = 0;

  sbus_core dut (
    .clk(clk), .rst(rst), .memRdata(memRdata), .memDone(memDone),
    .memAddr(memAddr), .memWdata(memWdata), .memRead(memRead),
    .memWrite(memWrite), .halted(halted)
  );

  always #10 clk = ~clk;

  // memory model: completes a request after lat falling edges
  initial forever begin
    @(negedge clk);
    if (rst || memDone) begin
      memDone = 1'b0;
      waitCnt = 0;
    end else if (memRead || memWrite) begin
      waitCnt++;
      if (waitCnt >= lat) begin
        memDone = 1'b1;
        if (memRead) begin
          memRdata = mem[memAddr[7:0]];
          if (rdCount < 64) rdLog[rdCount] = memAddr;
          rdCount++;
        end else begin
          mem[memAddr[7:0]] = memWdata;
          if (wrCount < 64) begin
            wrAddr[wrCount] = memAddr;
            wrData[wrCount] = memWdata;
          end
          wrCount++;
        end
      end
    end
  end

  initial begin
    #(20ns * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startCore(input int latency);
    @(negedge clk);
    rst = 1'b1;
    lat = latency;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rdCount = 0;
    wrCount = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic runToHalt(output int cycles);
    cycles = 0;
    rst = 1'b0;
    while (!halted && cycles < 3000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic testReset();
    startCore(2);
    check(memRead == 1'b0 && memWrite == 1'b0, "R1 no request in reset",
          {memRead, memWrite}, 0);
    check(halted == 1'b0, "R1 halted clear in reset", halted, 0);
  endtask

  // loads, move, adds, store; latency given
  task automatic testProgramA(input int latency);
    int n;
    int expCycles;
    startCore(latency);
    mem[0] = 16'h110F;  // load R1,[R0]; low nibble ignored (R5)
    mem[1] = 16'h1210;  // load R2,[R1]
    mem[2] = 16'h1320;  // load R3,[R2]
    mem[3] = 16'h3430;  // move R4,R3
    mem[4] = 16'h4430;  // add R4,R3
    mem[5] = 16'h443A;  // add R4,R3; nonzero ignored nibble (R5)
    mem[6] = 16'h2240;  // store [R2],R4
    mem[7] = 16'h0000;  // stop
    mem[8'h0F] = 16'h0020;
    mem[8'h20] = 16'h1234;
    runToHalt(n);
    expCycles = 3 * (2 * latency + 4) + (latency + 3) + 2 * (latency + 5)
              + (2 * latency + 4) + (latency + 3);
    check(n == expCycles, "R4 R6 R8 R9 cycle count", n, expCycles);
    check(rdLog[0] == 16'h0000, "R1 first fetch address", rdLog[0], 0);
    check(rdLog[2] == 16'h0001, "R2 second fetch address", rdLog[2], 1);
    check(rdLog[3] == 16'h110F, "R6 load address full width", rdLog[3], 16'h110F);
    check(rdCount == 11, "R2 R6 read count", rdCount, 11);
    check(wrCount == 1, "R7 single write", wrCount, 1);
    check(wrAddr[0] == 16'h0020, "R7 store address", wrAddr[0], 16'h20);
    check(wrData[0] == 16'h369C, "R5 R8 R9 stored sum", wrData[0], 16'h369C);
  endtask

  task automatic testProgramB();
    int n;
    int rdSnap;
    startCore(1);
    check(halted == 1'b0, "R1 halted cleared by reset", halted, 0);
    mem[0] = 16'h110F;  // load R1,[R0]
    mem[1] = 16'h1210;  // load R2,[R1] -> FFFF
    mem[2] = 16'h4220;  // add R2,R2 -> FFFE
    mem[3] = 16'h2120;  // store [R1],R2
    mem[4] = 16'h3620;  // move R6,R2
    mem[5] = 16'h2060;  // store [R0],R6
    mem[6] = 16'hF000;  // undefined opcode
    mem[8'h0F] = 16'hFFFF;
    runToHalt(n);
    check(n == 38, "R7 R9 R10 cycle count", n, 38);
    check(wrCount == 2, "R7 write count", wrCount, 2);
    check(wrAddr[0] == 16'h110F && wrData[0] == 16'hFFFE, "R9 wrapped sum stored",
          wrData[0], 16'hFFFE);
    check(wrAddr[1] == 16'h0000 && wrData[1] == 16'hFFFE, "R8 moved value stored",
          wrData[1], 16'hFFFE);
    rdSnap = rdCount;
    repeat (20) @(negedge clk);
    check(halted == 1'b1, "R10 halted sticky", halted, 1);
    check(rdCount == rdSnap && wrCount == 2, "R10 no memory after halt",
          rdCount, rdSnap);
  endtask

  task automatic testImmediateStop();
    int n;
    startCore(3);
    mem[0] = 16'h5ABC;
    runToHalt(n);
    check(n == 6, "R2 R10 fetch then halt", n, 6);
    repeat (10) @(negedge clk);
    check(rdCount == 1 && wrCount == 0, "R10 one fetch only", rdCount, 1);
  endtask

  initial begin
    testReset();
    testProgramA(2);
    testProgramA(5);
    testProgramB();
    testImmediateStop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule